// File: doc/BRIEF.md
# Page-Mapped Flash Translation Layer

This block places a logical page store in front of a modelled flash array whose erase blocks each hold a fixed number of pages. The host reads and writes whole pages by logical page number. Logical pages are split into groups of one erase block's worth. Each group owns one physical block, and a page keeps its offset inside that block. A valid bit per logical page records whether it has ever been written. A program bit per physical page records whether that page has been programmed since its block was last erased.

A write to a page whose physical slot is still erased is programmed in place in a single cycle. A write to a slot that is already programmed cannot be done in place. The block then picks a spare block: of the blocks that no group owns, the one with the fewest erases wins. It walks the old block one offset per cycle, copying every valid page forward and placing the new data at its own offset. It then repoints the group at the new block and erases the old one over a parameterised number of busy cycles. The old block's erase count goes up by one and the block joins the spare pool.

Ready stays low for the whole copy-and-erase sequence. Requests presented while ready is low are dropped.

Top module: `ftl_pagemap`

## Requirements
- R1: After reset, ready is high and rd_valid is low, and a read of any logical page that was never written returns all zeros.
- R2: A read is accepted on a cycle where ready and req_rd are high and req_wr is low. rd_valid is high on the next cycle only, and rd_data then carries the newest data written to that page.
- R3: A write to a page whose physical slot has not been programmed since its last erase is accepted in one cycle, and ready stays high.
- R4: A write to a page whose slot is already programmed starts a relocation. Ready is low for exactly PAGES_PER_BLK + ERASE_CYCLES cycles after the accepting edge, and every request presented in that time is ignored.
- R5: After a relocation, the rewritten page reads back its new data, every other written page of the same group reads back unchanged, and unwritten pages of the group still read zero.
- R6: The relocation target is the unowned block with the lowest erase count, ties going to the lowest block index. Its index is shown on reloc_blk while ready is low.
- R7: The old block of a relocation is erased: its erase count rises by one and it becomes a spare block available to later relocations.
- R8: No physical page is ever programmed twice without an erase of its block in between.
- R9: When req_wr and req_rd are both high on an accepted cycle, only the write is performed and no read result is produced.
- R10: A write or relocation in one group leaves the contents of all other groups unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_wr | input | 1 | Write request for req_page |
| req_rd | input | 1 | Read request for req_page |
| req_page | input | LAW | Logical page number, below NUM_GROUPS*PAGES_PER_BLK |
| req_data | input | DW | Page data for a write |
| ready | output | 1 | High when a request can be accepted |
| rd_valid | output | 1 | One-cycle strobe for read data |
| rd_data | output | DW | Read data, zero for never-written pages |
| reloc_blk | output | BW | Block chosen by the most recent relocation |

## Verification
The bench first reads every page straight after reset. This separates real zero-fill from stale array contents. First writes to several offsets of different groups show in-place programming with no stall. Repeated rewrites of the same page, of its neighbours, of other groups and of the last offset force a chain of relocations. That chain shows whether the spare choice follows erase counts rather than index order, and whether copy-forward misses or duplicates a page. Writes and reads pushed in while ready is low, and a combined write-read cycle, show whether dropped and lower-priority requests really leave no trace.

// File: rtl/ftl_pagemap.sv
module ftl_pagemap #(
  parameter int DW            = 16,
  parameter int PAGES_PER_BLK = 32,
  parameter int NUM_BLOCKS    = 6,
  parameter int NUM_GROUPS    = 3,
  parameter int ERASE_CYCLES  = 40,
  parameter int ECW           = 17,
  localparam int LP  = NUM_GROUPS * PAGES_PER_BLK,
  localparam int LAW = $clog2(LP),
  localparam int BW  = $clog2(NUM_BLOCKS)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_wr,
  input  logic           req_rd,
  input  logic [LAW-1:0] req_page,
  input  logic [DW-1:0]  req_data,
  output logic           ready,
  output logic           rd_valid,
  output logic [DW-1:0]  rd_data,
  output logic [BW-1:0]  reloc_blk
);
  localparam int NPP = NUM_BLOCKS * PAGES_PER_BLK;
  localparam int PW  = $clog2(NPP);
  localparam int OW  = $clog2(PAGES_PER_BLK);
  localparam int GW  = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1;
  localparam int CW  = $clog2(ERASE_CYCLES + 1);

  typedef enum logic [1:0] {S_IDLE, S_COPY, S_ERASE} state_t;

  function automatic logic [PW-1:0] pa(input logic [BW-1:0] b, input logic [OW-1:0] o);
    return PW'(b) * PW'(PAGES_PER_BLK) + PW'(o);
  endfunction

  function automatic logic [LAW-1:0] la(input logic [GW-1:0] g, input logic [OW-1:0] o);
    return LAW'(g) * LAW'(PAGES_PER_BLK) + LAW'(o);
  endfunction

  logic [DW-1:0]  mem [NPP];
  logic [NPP-1:0] pgm;
  logic [LP-1:0]  vld;
  logic [BW-1:0]  owner [NUM_GROUPS];
  logic [ECW-1:0] ecnt [NUM_BLOCKS];

  state_t         state;
  logic [BW-1:0]  src, dst;
  logic [GW-1:0]  grp;
  logic [OW-1:0]  off, idx;
  logic [DW-1:0]  wdat;
  logic [CW-1:0]  ecyc;

  logic [GW-1:0]  cur_g;
  logic [OW-1:0]  cur_o;
  logic [PW-1:0]  hit_pa;
  logic           acc_wr, acc_rd, need_reloc;
  logic [NUM_BLOCKS-1:0] owned;
  logic [BW-1:0]  best;
  logic           found;
  logic           we;
  logic [PW-1:0]  waddr;
  logic [DW-1:0]  wdata;
  logic [ECW-1:0] src_cnt;

  assign ready      = (state == S_IDLE);
  assign reloc_blk  = dst;
  assign cur_g      = GW'(req_page / LAW'(PAGES_PER_BLK));
  assign cur_o      = OW'(req_page % LAW'(PAGES_PER_BLK));
  assign hit_pa     = pa(owner[cur_g], cur_o);
  assign acc_wr     = ready & req_wr;
  assign acc_rd     = ready & req_rd & ~req_wr;
  assign need_reloc = pgm[hit_pa];
  assign src_cnt    = ecnt[src];

  always_comb begin
    owned = '0;
    for (int g = 0; g < NUM_GROUPS; g++) owned[owner[g]] = 1'b1;
    best  = '0;
    found = 1'b0;
    for (int b = 0; b < NUM_BLOCKS; b++) begin
      if (!owned[b] && (!found || ecnt[b] < ecnt[best])) begin
        best  = BW'(b);
        found = 1'b1;
      end
    end
  end

  always_comb begin
    we    = 1'b0;
    waddr = hit_pa;
    wdata = req_data;
    if (state == S_IDLE) begin
      we = acc_wr & ~need_reloc;
    end else if (state == S_COPY) begin
      we    = (idx == off) | vld[la(grp, idx)];
      waddr = pa(dst, idx);
      wdata = (idx == off) ? wdat : mem[pa(src, idx)];
    end
  end

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      pgm      <= '0;
      vld      <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
      src      <= '0;
      dst      <= '0;
      grp      <= '0;
      off      <= '0;
      idx      <= '0;
      wdat     <= '0;
      ecyc     <= '0;
      for (int g = 0; g < NUM_GROUPS; g++) owner[g] <= BW'(g);
      for (int b = 0; b < NUM_BLOCKS; b++) ecnt[b] <= '0;
    end else begin
      rd_valid <= acc_rd;
      if (we) pgm[waddr] <= 1'b1;
      case (state)
        S_IDLE: begin
          if (acc_rd) rd_data <= vld[req_page] ? mem[hit_pa] : '0;
          if (acc_wr && !need_reloc) vld[req_page] <= 1'b1;
          if (acc_wr && need_reloc) begin
            src   <= owner[cur_g];
            dst   <= best;
            grp   <= cur_g;
            off   <= cur_o;
            wdat  <= req_data;
            idx   <= '0;
            state <= S_COPY;
          end
        end
        S_COPY: begin
          idx <= idx + OW'(1);
          if (idx == OW'(PAGES_PER_BLK - 1)) begin
            owner[grp] <= dst;
            ecyc       <= CW'(ERASE_CYCLES - 1);
            state      <= S_ERASE;
          end
        end
        S_ERASE: begin
          if (ecyc == '0) begin
            for (int o = 0; o < PAGES_PER_BLK; o++) pgm[pa(src, OW'(o))] <= 1'b0;
            ecnt[src] <= ecnt[src] + ECW'(1);
            state     <= S_IDLE;
          end else begin
            ecyc <= ecyc - CW'(1);
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_prog_erased_R8: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> !pgm[waddr]);

  assert_read_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(req_rd && !req_wr && ready));

  assert_busy_drops_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |=> !rd_valid);

  assert_fresh_target_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_COPY) |-> (dst != src && !owned[dst]));

  assert_erase_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_ERASE && ecyc == '0) |=> (src_cnt == $past(src_cnt) + ECW'(1)));
endmodule

// File: tb/sim_ftl_pagemap.sv
module sim_ftl_pagemap;
  localparam int DW = 16, PPB = 32, NB = 6, NG = 3, EC = 40;
  localparam int LP = NG * PPB;
  localparam int LAW = $clog2(LP);
  localparam int BW = $clog2(NB);
  localparam int TOT = PPB + EC;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_wr = 1'b0, req_rd = 1'b0;
  logic [LAW-1:0] req_page = '0;
  logic [DW-1:0] req_data = '0;
  logic ready, rd_valid;
  logic [DW-1:0] rd_data;
  logic [BW-1:0] reloc_blk;

  ftl_pagemap #(.DW(DW), .PAGES_PER_BLK(PPB), .NUM_BLOCKS(NB), .NUM_GROUPS(NG),
                .ERASE_CYCLES(EC)) u0 (
    .clk(clk), .rst_n(rst_n), .req_wr(req_wr), .req_rd(req_rd), .req_page(req_page),
    .req_data(req_data), .ready(ready), .rd_valid(rd_valid), .rd_data(rd_data),
    .reloc_blk(reloc_blk));

  always #4 clk = ~clk;

  int checks = 0, errors = 0;
  int owner_m [NG];
  int ecnt_m [NB];
  bit pgm_m [NB*PPB];
  bit vld_m [LP];
  int dat_m [LP];
  int busy_left = 0;
  bit exp_rdv = 0;
  int exp_rdd = 0;
  int exp_rb = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int g = 0; g < NG; g++) owner_m[g] = g;
      for (int b = 0; b < NB; b++) ecnt_m[b] = 0;
      for (int i = 0; i < NB*PPB; i++) pgm_m[i] = 0;
      for (int i = 0; i < LP; i++) begin vld_m[i] = 0; dat_m[i] = 0; end
      busy_left = 0; exp_rdv = 0; exp_rdd = 0; exp_rb = 0;
    end else begin
      bit rdy;
      int p, g, o, ph, best;
      bit is_owned;
      rdy = (busy_left == 0);
      if (busy_left > 0) busy_left--;
      exp_rdv = 0;
      p = int'(req_page); g = p / PPB; o = p % PPB;
      if (rdy && req_wr) begin
        ph = owner_m[g] * PPB + o;
        if (!pgm_m[ph]) begin
          pgm_m[ph] = 1; vld_m[p] = 1; dat_m[p] = int'(req_data);
        end else begin
          best = -1;
          for (int b = 0; b < NB; b++) begin
            is_owned = 0;
            for (int k = 0; k < NG; k++) if (owner_m[k] == b) is_owned = 1;
            if (!is_owned && (best < 0 || ecnt_m[b] < ecnt_m[best])) best = b;
          end
          vld_m[p] = 1; dat_m[p] = int'(req_data);
          for (int i = 0; i < PPB; i++) begin
            if (vld_m[g*PPB+i]) pgm_m[best*PPB+i] = 1;
            pgm_m[owner_m[g]*PPB+i] = 0;
          end
          ecnt_m[owner_m[g]]++;
          owner_m[g] = best;
          exp_rb = best;
          busy_left = TOT;
        end
      end else if (rdy && req_rd) begin
        exp_rdv = 1;
        exp_rdd = vld_m[p] ? dat_m[p] : 0;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(ready == (busy_left == 0), "R4 ready", int'(ready), int'(busy_left == 0));
      chk(rd_valid == exp_rdv, "R2 rd_valid", int'(rd_valid), int'(exp_rdv));
      if (exp_rdv) chk(int'(rd_data) == exp_rdd, "R5/R10 rd_data", int'(rd_data), exp_rdd);
      if (busy_left > 0) chk(int'(reloc_blk) == exp_rb, "R6 reloc_blk", int'(reloc_blk), exp_rb);
    end
  end

  task automatic wait_idle();
    while (busy_left != 0) @(negedge clk);
  endtask

  task automatic wr(input int p, input int d);
    req_wr = 1; req_page = LAW'(p); req_data = DW'(d);
    @(negedge clk);
    req_wr = 0;
  endtask

  task automatic rd(input int p);
    req_rd = 1; req_page = LAW'(p);
    @(negedge clk);
    req_rd = 0;
  endtask

  task automatic fresh_wr(input int p, input int d);
    wait_idle();
    wr(p, d);
    chk(ready == 1'b1, "R3 no stall on erased slot", int'(ready), 1);
  endtask

  task automatic rewrite(input int p, input int d);
    wait_idle();
    wr(p, d);
    chk(ready == 1'b0, "R4 relocation started", int'(ready), 0);
    wr(p ^ 1, 16'hdead);
    rd(p);
    wait_idle();
    @(negedge clk);
  endtask

  task automatic read_group(input int g);
    for (int i = 0; i < PPB; i++) rd(g * PPB + i);
    @(negedge clk);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1;
    chk(ready == 1'b1, "R1 ready after reset", int'(ready), 1);
    chk(rd_valid == 1'b0, "R1 rd_valid after reset", int'(rd_valid), 0);
    for (int p = 0; p < LP; p++) rd(p);
    @(negedge clk);

    for (int i = 0; i < 6; i++) fresh_wr(i, 16'h100 + i);
    fresh_wr(PPB - 1, 16'h1ff);
    fresh_wr(PPB + 8, 16'h208);
    fresh_wr(2*PPB + 5, 16'h305);
    read_group(0);

    // R9: write wins over a simultaneous read
    req_wr = 1; req_rd = 1; req_page = LAW'(10); req_data = 16'h0a0a;
    @(negedge clk);
    req_wr = 0; req_rd = 0;
    chk(rd_valid == 1'b0, "R9 no read on combined cycle", int'(rd_valid), 0);
    rd(10);
    @(negedge clk);

    // R4/R5/R6/R7/R8: relocation chain, spare choice follows erase counts
    rewrite(2, 16'h0222);
    read_group(0);
    read_group(1);
    rewrite(3, 16'h0333);
    rewrite(PPB + 8, 16'h0288);
    read_group(1);
    rewrite(2*PPB + 5, 16'h0355);
    rewrite(PPB - 1, 16'h01ee);
    rewrite(0, 16'h0abc);
    rewrite(2, 16'h0444);
    // R10: every group after the chain
    for (int g = 0; g < NG; g++) read_group(g);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule